// File: doc/BRIEF.md
# Direct-Mapped Window Address Translator

This block is the first stage of virtual-to-physical translation. Each cycle it takes a virtual address, the current privilege mode, two mode-control bits and four direct-mapped window registers. It decides whether the address can be translated without any page tables. If it can, it produces the physical address with full read, write and execute permission. If not, it either reports a bad-address fault or hands the request on to the TLB and page walker, which are outside this block.

The block has three paths. In untranslated (direct) mode, the address is cut to the physical width and passed through. Otherwise, the four windows are checked in a fixed priority order. A window applies only when its privilege-enable bit for the current mode is set and its segment field matches the top bits of the address. In 64-bit mode the segment is the address nibble above bit 60, and a hit passes the address through clipped to the virtual width. In 32-bit mode the segment is the three bits above bit 29, and a hit replaces that segment with the window's own physical segment. Only when every window misses does the block check that the address is in canonical sign-extended form.

All outputs are registered, so a result appears one clock after its inputs are sampled.

Top module: `dmw_xlate`

## Requirements
- R1: While rst_ni is low, and after it is released until the first sampled input, kind_o is 0, pa_o is 0 and perm_o is 0.
- R2: The outputs show the result for the inputs sampled at the previous rising clock edge. They do not change between edges.
- R3: When da_i=1 and pg_i=0, kind_o becomes 1 (direct), pa_o becomes va_i[PA_W-1:0] and perm_o becomes 3'b111, whatever the windows hold.
- R4: The privilege mask has bit 0 set for priv_i=0 (kernel) and bit 3 set for priv_i=3 (user), and is zero for priv_i of 1 or 2. A window can hit only if this mask ANDed with window bits [3:0] is nonzero.
- R5: In 64-bit mode (mode64_i=1), a window's segment field is window bits [63:60], compared with va_i[63:60].
- R6: In 32-bit mode (mode64_i=0), a window's segment field is window bits [31:29], compared with va_i[31:29].
- R7: Windows are checked in index order 0, 1, 2, 3, and the lowest-numbered hitting window decides the result. Window i occupies win_i[64*i+63:64*i].
- R8: A 64-bit mode hit gives kind_o=2 (window), perm_o=3'b111 and pa_o equal to va_i with bits at and above VIRT_W cleared. This holds even if va_i is not canonical.
- R9: A 32-bit mode hit gives kind_o=2, perm_o=3'b111 and pa_o equal to {window bits [27:25], va_i[28:0]}, zero-extended.
- R10: A window miss with va_i[63:VIRT_W-1] all zeros or all ones gives kind_o=0 (walk), pa_o=0 and perm_o=0.
- R11: A window miss with va_i[63:VIRT_W-1] neither all zeros nor all ones gives kind_o=3 (bad address), pa_o=0 and perm_o=0.
- R12: When da_i=0, or when pg_i=1, the direct path is not taken and the window and canonical checks decide the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| va_i | input | VA_W (64) | Virtual address |
| priv_i | input | 2 | Privilege mode: 0 kernel, 3 user |
| da_i | input | 1 | Direct-address mode bit |
| pg_i | input | 1 | Paging-enable bit |
| mode64_i | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| win_i | input | NUM_WIN*WIN_W (256) | Four window registers, window 0 in the low bits |
| kind_o | output | 2 | 0 walk, 1 direct, 2 window hit, 3 bad address |
| pa_o | output | PA_W (48) | Physical address |
| perm_o | output | 3 | Permissions {read, write, execute} |

## Verification
The bench builds the block with the default parameters: 64-bit addresses, a 48-bit virtual width, a 48-bit physical width, and segment shifts of 60 and 29. With these values the canonical boundary sits at bit 47. This puts both edges of the sign-extended range within reach: 0x0000_7FFF_FFFF_F000 against 0x0000_8000_0000_0000, and 0xFFFF_8000_0000_1000 against 0xFFFF_7FFF_FFFF_FFFF. The 3-bit physical segment at bits 27:25 lets every window carry a distinct replacement segment, so a 32-bit hit shows which window won the priority order. A 64-bit hit on a non-canonical address shows that the canonical check runs only after all windows miss.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  typedef enum logic [1:0] {
    XL_WALK    = 2'd0,
    XL_DIRECT  = 2'd1,
    XL_WINDOW  = 2'd2,
    XL_BADADDR = 2'd3
  } xl_kind_e;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/dmw_win_match.sv
module dmw_win_match #(
  parameter int WIN_W       = 64,
  parameter int VA_W        = 64,
  parameter int VIRT_W      = 48,
  parameter int PA_W        = 48,
  parameter int SEG64_SHIFT = 60,
  parameter int SEG32_SHIFT = 29,
  parameter int PSEG_LSB    = 25
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [3:0]       priv_mask_i,
  input  logic             mode64_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  pa_o
);
  localparam int SEG64_W = VA_W - SEG64_SHIFT;
  localparam int SEG32_W = 32 - SEG32_SHIFT;
  localparam logic [VA_W-1:0] VIRT_MASK = (VA_W'(1) << VIRT_W) - VA_W'(1);

  logic              priv_ok;
  logic              seg64_eq;
  logic              seg32_eq;
  logic [VA_W-1:0]   va_virt;
  logic [31:0]       pa32;
  logic [SEG32_W-1:0] pseg;

  assign priv_ok  = |(priv_mask_i & win_i[3:0]);
  assign seg64_eq = win_i[WIN_W-1 -: SEG64_W] == va_i[VA_W-1 -: SEG64_W];
  assign seg32_eq = win_i[31 -: SEG32_W] == va_i[31 -: SEG32_W];
  assign hit_o    = priv_ok && (mode64_i ? seg64_eq : seg32_eq);

  assign va_virt = va_i & VIRT_MASK;
  assign pseg    = win_i[PSEG_LSB +: SEG32_W];
  assign pa32    = {pseg, va_i[SEG32_SHIFT-1:0]};
  assign pa_o    = mode64_i ? va_virt[PA_W-1:0] : PA_W'(pa32);
endmodule

// File: rtl/dmw_first_hit.sv
module dmw_first_hit #(
  parameter int N    = 4,
  parameter int PA_W = 48
) (
  input  logic [N-1:0]      hit_i,
  input  logic [N*PA_W-1:0] pa_i,
  output logic              any_o,
  output logic [N-1:0]      sel_o,
  output logic [PA_W-1:0]   pa_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = '0;
    pa_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i] && !found) begin
        found    = 1'b1;
        sel_o[i] = 1'b1;
        pa_o     = pa_i[i*PA_W +: PA_W];
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/dmw_canon.sv
module dmw_canon #(
  parameter int VA_W   = 64,
  parameter int VIRT_W = 48
) (
  input  logic [VA_W-1:0] va_i,
  output logic            ok_o
);
  localparam int HI_W = VA_W - VIRT_W + 1;
  logic [HI_W-1:0] hi;
  assign hi   = va_i[VA_W-1 -: HI_W];
  assign ok_o = (&hi) || !(|hi);
endmodule

// File: rtl/dmw_xlate.sv
module dmw_xlate
  import dmw_pkg::*;
#(
  parameter int NUM_WIN     = 4,
  parameter int WIN_W       = 64,
  parameter int VA_W        = 64,
  parameter int VIRT_W      = 48,
  parameter int PA_W        = 48,
  parameter int SEG64_SHIFT = 60,
  parameter int SEG32_SHIFT = 29,
  parameter int PSEG_LSB    = 25
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [VA_W-1:0]          va_i,
  input  logic [1:0]               priv_i,
  input  logic                     da_i,
  input  logic                     pg_i,
  input  logic                     mode64_i,
  input  logic [NUM_WIN*WIN_W-1:0] win_i,
  output logic [1:0]               kind_o,
  output logic [PA_W-1:0]          pa_o,
  output logic [2:0]               perm_o
);
  logic [3:0]            priv_mask;
  logic [NUM_WIN-1:0]    win_hit;
  logic [NUM_WIN*PA_W-1:0] win_pa;
  logic                  win_any;
  logic [NUM_WIN-1:0]    win_sel;
  logic [PA_W-1:0]       sel_pa;
  logic                  canon_ok;
  logic                  direct;

  xl_kind_e              kind_n, kind_q;
  logic [PA_W-1:0]       pa_n, pa_q;
  logic [2:0]            perm_n, perm_q;
  logic                  started_q;

  assign priv_mask = {priv_i == 2'd3, 2'b00, priv_i == 2'd0};
  assign direct    = da_i && !pg_i;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    dmw_win_match #(
      .WIN_W(WIN_W), .VA_W(VA_W), .VIRT_W(VIRT_W), .PA_W(PA_W),
      .SEG64_SHIFT(SEG64_SHIFT), .SEG32_SHIFT(SEG32_SHIFT), .PSEG_LSB(PSEG_LSB)
    ) u_match (
      .win_i      (win_i[g*WIN_W +: WIN_W]),
      .va_i       (va_i),
      .priv_mask_i(priv_mask),
      .mode64_i   (mode64_i),
      .hit_o      (win_hit[g]),
      .pa_o       (win_pa[g*PA_W +: PA_W])
    );
  end

  dmw_first_hit #(.N(NUM_WIN), .PA_W(PA_W)) u_pick (
    .hit_i(win_hit),
    .pa_i (win_pa),
    .any_o(win_any),
    .sel_o(win_sel),
    .pa_o (sel_pa)
  );

  dmw_canon #(.VA_W(VA_W), .VIRT_W(VIRT_W)) u_canon (
    .va_i(va_i),
    .ok_o(canon_ok)
  );

  always_comb begin
    kind_n = XL_WALK;
    pa_n   = '0;
    perm_n = PERM_NONE;
    if (direct) begin
      kind_n = XL_DIRECT;
      pa_n   = va_i[PA_W-1:0];
      perm_n = PERM_ALL;
    end else if (win_any) begin
      kind_n = XL_WINDOW;
      pa_n   = sel_pa;
      perm_n = PERM_ALL;
    end else if (!canon_ok) begin
      kind_n = XL_BADADDR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q    <= XL_WALK;
      pa_q      <= '0;
      perm_q    <= PERM_NONE;
      started_q <= 1'b0;
    end else begin
      kind_q    <= kind_n;
      pa_q      <= pa_n;
      perm_q    <= perm_n;
      started_q <= 1'b1;
    end
  end

  assign kind_o = kind_q;
  assign pa_o   = pa_q;
  assign perm_o = perm_q;

  // R7: at most one window is selected
  p_sel_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_sel));

  // R3: direct mode wins over everything
  p_direct_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(da_i && !pg_i) |-> kind_o == XL_DIRECT);

  // R8: hit kinds carry full permission
  p_perm_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == XL_WINDOW || kind_o == XL_DIRECT) |-> perm_o == PERM_ALL);

  // R10/R11: miss kinds carry no permission and a zero address
  p_miss_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == XL_WALK || kind_o == XL_BADADDR) |-> (perm_o == PERM_NONE && pa_o == '0));

  // R11: a non-canonical miss faults
  p_bad_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(!(da_i && !pg_i) && !win_any && !canon_ok) |-> kind_o == XL_BADADDR);

  // R12: a window hit outside direct mode is reported as a window
  p_win_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(!(da_i && !pg_i) && win_any) |-> kind_o == XL_WINDOW);
endmodule

// File: tb/tb_dmw_xlate.sv
module tb_dmw_xlate;
  localparam int NW = 4;
  localparam int WW = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [63:0]       va = '0;
  logic [1:0]        priv = 2'd0;
  logic              da = 1'b0;
  logic              pg = 1'b0;
  logic              m64 = 1'b1;
  logic [NW*WW-1:0]  win = '0;
  logic [1:0]        kind;
  logic [47:0]       pa;
  logic [2:0]        perm;

  int chk_cnt = 0;
  int fail_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dmw_xlate #(
    .NUM_WIN(NW), .WIN_W(WW), .VA_W(64), .VIRT_W(48), .PA_W(48),
    .SEG64_SHIFT(60), .SEG32_SHIFT(29), .PSEG_LSB(25)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .va_i(va), .priv_i(priv), .da_i(da),
    .pg_i(pg), .mode64_i(m64), .win_i(win), .kind_o(kind), .pa_o(pa), .perm_o(perm)
  );

  function automatic logic [63:0] w64(input logic [3:0] vseg, input logic [3:0] plv);
    return {vseg, 56'd0, plv};
  endfunction

  function automatic logic [63:0] w32(input logic [2:0] vseg, input logic [2:0] pseg,
                                      input logic [3:0] plv);
    return {32'd0, vseg, 1'b0, pseg, 21'd0, plv};
  endfunction

  task automatic check(input string req, input logic [1:0] ek, input logic [47:0] ep,
                       input logic [2:0] em);
    chk_cnt++;
    if (kind !== ek || pa !== ep || perm !== em) begin
      fail_cnt++;
      $display("FAIL %s: kind=%0d pa=%h perm=%b, expected kind=%0d pa=%h perm=%b",
               req, kind, pa, perm, ek, ep, em);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [1:0] p, input logic d,
                       input logic g, input logic m,
                       input logic [63:0] w0, input logic [63:0] w1,
                       input logic [63:0] w2, input logic [63:0] w3);
    va = a; priv = p; da = d; pg = g; m64 = m; win = {w3, w2, w1, w0};
    @(negedge clk);
  endtask

  task automatic t_reset;
    // R1
    check("R1", 2'd0, 48'd0, 3'b000);
  endtask

  task automatic t_direct;
    apply(64'h9000_1234_5678_9ABC, 2'd0, 1'b1, 1'b0, 1'b1,
          w64(4'h9, 4'b0001), 64'd0, 64'd0, 64'd0);
    check("R3", 2'd1, 48'h1234_5678_9ABC, 3'b111);
    apply(64'h0000_8000_0000_0042, 2'd1, 1'b1, 1'b0, 1'b0, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R3", 2'd1, 48'h8000_0000_0042, 3'b111);
  endtask

  task automatic t_paging_on;
    apply(64'h9000_1234_5678_9ABC, 2'd0, 1'b1, 1'b1, 1'b1,
          w64(4'h9, 4'b0001), 64'd0, 64'd0, 64'd0);
    check("R12", 2'd2, 48'h1234_5678_9ABC, 3'b111);
    apply(64'h9000_1234_5678_9ABC, 2'd0, 1'b0, 1'b0, 1'b1,
          w64(4'h9, 4'b0001), 64'd0, 64'd0, 64'd0);
    check("R12", 2'd2, 48'h1234_5678_9ABC, 3'b111);
  endtask

  task automatic t_latency;
    apply(64'h0000_0000_0000_1000, 2'd0, 1'b1, 1'b0, 1'b1, 64'd0, 64'd0, 64'd0, 64'd0);
    va = 64'h0000_0000_0000_2000;
    #2;
    check("R2", 2'd1, 48'h0000_0000_1000, 3'b111);
    @(negedge clk);
    check("R2", 2'd1, 48'h0000_0000_2000, 3'b111);
  endtask

  task automatic t_priv;
    apply(64'h9000_0000_0000_0010, 2'd3, 1'b0, 1'b1, 1'b1,
          w64(4'h9, 4'b0001), 64'd0, 64'd0, 64'd0);
    check("R4", 2'd3, 48'd0, 3'b000);
    apply(64'h9000_0000_0000_0010, 2'd0, 1'b0, 1'b1, 1'b1,
          w64(4'h9, 4'b0001), 64'd0, 64'd0, 64'd0);
    check("R4", 2'd2, 48'h0000_0000_0010, 3'b111);
    apply(64'h9000_0000_0000_0010, 2'd1, 1'b0, 1'b1, 1'b1,
          w64(4'h9, 4'b1111), 64'd0, 64'd0, 64'd0);
    check("R4", 2'd3, 48'd0, 3'b000);
    apply(64'h9000_0000_0000_0010, 2'd3, 1'b0, 1'b1, 1'b1,
          w64(4'h9, 4'b1000), 64'd0, 64'd0, 64'd0);
    check("R4", 2'd2, 48'h0000_0000_0010, 3'b111);
    apply(64'h9000_0000_0000_0010, 2'd0, 1'b0, 1'b1, 1'b1,
          w64(4'h9, 4'b1000), 64'd0, 64'd0, 64'd0);
    check("R4", 2'd3, 48'd0, 3'b000);
  endtask

  task automatic t_seg64;
    apply(64'h9000_0000_0000_0010, 2'd0, 1'b0, 1'b1, 1'b1,
          w64(4'h8, 4'b0001), 64'd0, 64'd0, 64'd0);
    check("R5", 2'd3, 48'd0, 3'b000);
    // R8: non-canonical address still hits a window
    apply(64'hF000_ABCD_0000_1111, 2'd0, 1'b0, 1'b1, 1'b1,
          64'd0, 64'd0, w64(4'hF, 4'b0001), 64'd0);
    check("R8", 2'd2, 48'hABCD_0000_1111, 3'b111);
  endtask

  task automatic t_seg32;
    apply(64'h0000_0000_A123_4567, 2'd0, 1'b0, 1'b1, 1'b0,
          w32(3'd5, 3'd3, 4'b0001), 64'd0, 64'd0, 64'd0);
    check("R6", 2'd2, 48'h0000_6123_4567, 3'b111);
    // R9: segment replaced by window pseg
    apply(64'h0000_0000_A123_4567, 2'd3, 1'b0, 1'b1, 1'b0,
          w32(3'd5, 3'd0, 4'b1000), 64'd0, 64'd0, 64'd0);
    check("R9", 2'd2, 48'h0000_0123_4567, 3'b111);
    apply(64'h0000_0000_A123_4567, 2'd0, 1'b0, 1'b1, 1'b0,
          w32(3'd4, 3'd3, 4'b0001), 64'd0, 64'd0, 64'd0);
    check("R6", 2'd0, 48'd0, 3'b000);
  endtask

  task automatic t_order;
    apply(64'h0000_0000_A123_4567, 2'd0, 1'b0, 1'b1, 1'b0,
          w32(3'd4, 3'd7, 4'b0001), w32(3'd5, 3'd1, 4'b0001),
          w32(3'd5, 3'd2, 4'b0001), w32(3'd5, 3'd6, 4'b0001));
    check("R7", 2'd2, 48'h0000_2123_4567, 3'b111);
    apply(64'h0000_0000_A123_4567, 2'd0, 1'b0, 1'b1, 1'b0,
          w32(3'd5, 3'd7, 4'b0001), w32(3'd5, 3'd1, 4'b0001),
          w32(3'd5, 3'd2, 4'b0001), w32(3'd5, 3'd6, 4'b0001));
    check("R7", 2'd2, 48'h0000_E123_4567, 3'b111);
    apply(64'h0000_0000_A123_4567, 2'd0, 1'b0, 1'b1, 1'b0,
          64'd0, w32(3'd5, 3'd1, 4'b1000), 64'd0, w32(3'd5, 3'd6, 4'b0001));
    check("R7", 2'd2, 48'h0000_C123_4567, 3'b111);
  endtask

  task automatic t_canon;
    apply(64'hFFFF_8000_0000_1000, 2'd0, 1'b0, 1'b1, 1'b1, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R10", 2'd0, 48'd0, 3'b000);
    apply(64'h0000_7FFF_FFFF_F000, 2'd0, 1'b0, 1'b1, 1'b1, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R10", 2'd0, 48'd0, 3'b000);
    apply(64'h0000_8000_0000_0000, 2'd0, 1'b0, 1'b1, 1'b1, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R11", 2'd3, 48'd0, 3'b000);
    apply(64'hFFFF_7FFF_FFFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b1, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R11", 2'd3, 48'd0, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_paging_on();
    t_latency();
    t_priv();
    t_seg64();
    t_seg32();
    t_order();
    t_canon();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk_cnt++;
      fail_cnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end
endmodule